// File: doc/BRIEF.md
# Controller button-state crosser and record emitter

This block takes a 32-bit button word held in a host-facing register clocked by a fast bridge clock and carries it into the core clock. A launch flop in the host domain feeds a two-flop synchronizer in the core domain. The synchronized word is turned into two active-low digital button bytes. Core-side software reads these bytes through a single memory-mapped status word.

On a send request, the block also takes a snapshot of the button bytes. It then streams a fixed 16-byte controller-state record as four 32-bit beats on a valid/ready/last stream, so that a downstream transfer engine can copy the record into memory. A requester reissues the request after each burst to refresh the record.

Top module: `pad_state_link`

## Requirements
- R1: A host word captured on a host-clock edge appears in the status word within 4 core-clock cycles. The path is one host-clock launch flop and then two core-clock flops. After reset every button reads as released.
- R2: A read enable gives read-valid on the next core cycle. The read data is the status word when the address equals 0x1F80_8500, and zero for any other address.
- R3: The status word carries the first button byte in bits [7:0] and the second button byte in bits [15:8]. Bits [31:16] read as zero. Buttons are active-low, so an all-zero host word reads as 0x0000FFFF.
- R4: Host bit 0 clears bit 5 of the first button byte, giving 0xDF. Host bit 5 clears bit 0 of the first button byte, giving 0xFE. Both bits together give 0xDE.
- R5: The other 30 host bits have no effect. The other six bits of the first button byte stay 1, and the second button byte stays 0xFF.
- R6: The record, as 32-bit words with the lowest byte in bits [7:0], is: word0 = {byte1, 0x5A, 0x41, 0x00}, word1 = {0x80, 0x80, 0x80, byte2}, word2 = 0x0000_0080, word3 = 0x0000_0000.
- R7: A record goes out as exactly four beats with word0 first. Last is high only on the fourth beat. Valid drops in the cycle after the fourth beat is accepted.
- R8: While valid is high and ready is low, valid, data and last hold their values.
- R9: A send request accepted while idle latches the button bytes. Host-word changes made after that point do not alter the burst in flight.
- R10: A send request made while a burst is in progress, including in the cycle of its final handshake, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bridge clock |
| hrst_n | input | 1 | Active-low reset, host domain |
| host_word | input | 32 | Button word, active-high bits, host domain |
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, core domain |
| rd_en | input | 1 | Status read request |
| rd_addr | input | 32 | Status read address |
| rd_data | output | 32 | Status read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| send_req | input | 1 | Start a record burst (taken only when idle) |
| tx_valid | output | 1 | Stream beat valid |
| tx_data | output | 32 | Stream beat data |
| tx_last | output | 1 | Final beat of record |
| tx_ready | input | 1 | Stream sink ready |

## Verification
A bad beat counter shows at the stream ports within one accepted beat. It appears as a word out of order, a missing or misplaced last flag, or valid staying high or dropping early. A snapshot that does not hold shows only when the host word changes during a stalled burst, so the bench deliberately moves the host word while ready is held low. A wrong bit mapping or synchronizer stage shows in the first status read after a settle window of a few core cycles.

// File: rtl/pad_fmt_pkg.sv
package pad_fmt_pkg;
  localparam int BEATS    = 4;
  localparam int BEAT_W   = 32;
  localparam int IDX_W    = $clog2(BEATS);

  // Active-low first button byte: host bit 0 -> byte bit 5, host bit 5 -> byte bit 0.
  function automatic logic [7:0] first_btn(input logic [31:0] w);
    logic [7:0] b;
    b    = 8'hFF;
    b[5] = ~w[0];
    b[0] = ~w[5];
    return b;
  endfunction

  // Second button byte has no mapped buttons; all released.
  function automatic logic [7:0] second_btn(input logic [31:0] w);
    logic [7:0] b;
    b = 8'hFF | w[7:0];
    return b;
  endfunction

  function automatic logic [BEAT_W-1:0] rec_word(input logic [IDX_W-1:0] idx,
                                                 input logic [7:0] b1,
                                                 input logic [7:0] b2);
    logic [BEAT_W-1:0] r;
    case (idx)
      2'd0:    r = {b1, 8'h5A, 8'h41, 8'h00};
      2'd1:    r = {8'h80, 8'h80, 8'h80, b2};
      2'd2:    r = 32'h0000_0080;
      default: r = 32'h0000_0000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int W = 32
) (
  input  logic         hclk,
  input  logic         hrst_n,
  input  logic [W-1:0] d_host,
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q_core
);
  logic [W-1:0] launch_q;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) launch_q <= '0;
    else         launch_q <= d_host;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= launch_q;
      sync_q <= meta_q;
    end
  end

  assign q_core = sync_q;
endmodule

// File: rtl/pad_status.sv
module pad_status #(
  parameter logic [31:0] STAT_ADDR = 32'h1F80_8500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word_sync,
  input  logic        rd_en,
  input  logic [31:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic [7:0]  btn1,
  output logic [7:0]  btn2
);
  import pad_fmt_pkg::*;

  logic addr_hit;
  logic [31:0] stat_word;

  assign btn1      = first_btn(word_sync);
  assign btn2      = second_btn(word_sync);
  assign addr_hit  = (rd_addr == STAT_ADDR);
  assign stat_word = {16'h0000, btn2, btn1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && addr_hit) ? stat_word : 32'h0;
    end
  end

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[31:16] == 16'h0);
  a_r5_unmapped_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((btn1 | 8'h21) == 8'hFF) && (btn2 == 8'hFF));
endmodule

// File: rtl/pad_record_tx.sv
module pad_record_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  btn1,
  input  logic [7:0]  btn2,
  input  logic        send_req,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic        tx_last
);
  import pad_fmt_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       snap1_q, snap2_q;
  logic             start_ev;
  logic             beat_ev;
  logic             final_ev;

  assign start_ev = !busy_q && send_req;
  assign beat_ev  = busy_q && tx_ready;
  assign final_ev = beat_ev && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      snap1_q <= 8'hFF;
      snap2_q <= 8'hFF;
    end else if (start_ev) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      snap1_q <= btn1;
      snap2_q <= btn2;
    end else if (final_ev) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else if (beat_ev) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = rec_word(idx_q, snap1_q, snap2_q);
  assign tx_last  = busy_q && (idx_q == LAST_IDX);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
  a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && $past(tx_valid) |-> $stable(snap1_q) && $stable(snap2_q));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(idx_q));
endmodule

// File: rtl/pad_state_link.sv
module pad_state_link #(
  parameter logic [31:0] STAT_ADDR = 32'h1F80_8500
) (
  input  logic        hclk,
  input  logic        hrst_n,
  input  logic [31:0] host_word,
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [31:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        send_req,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [31:0] word_sync;
  logic [7:0]  btn1, btn2;

  pad_sync #(.W(32)) u_sync (
    .hclk(hclk), .hrst_n(hrst_n), .d_host(host_word),
    .clk(clk), .rst_n(rst_n), .q_core(word_sync)
  );

  pad_status #(.STAT_ADDR(STAT_ADDR)) u_status (
    .clk(clk), .rst_n(rst_n), .word_sync(word_sync),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .btn1(btn1), .btn2(btn2)
  );

  pad_record_tx u_tx (
    .clk(clk), .rst_n(rst_n), .btn1(btn1), .btn2(btn2),
    .send_req(send_req), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

// File: tb/pad_state_link_bench.sv
`timescale 1ns/1ps
module pad_state_link_bench;
  localparam time CLK_PERIOD  = 10ns;
  localparam time HCLK_PERIOD = 4ns;
  localparam logic [31:0] STAT = 32'h1F80_8500;

  logic clk = 0, hclk = 0;
  logic rst_n = 0, hrst_n = 0;
  logic [31:0] host_word = 0;
  logic rd_en = 0;
  logic [31:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic rd_valid;
  logic send_req = 0;
  logic tx_valid, tx_last;
  logic [31:0] tx_data;
  logic tx_ready = 0;

  always #(CLK_PERIOD/2)  clk  = ~clk;
  always #(HCLK_PERIOD/2) hclk = ~hclk;

  pad_state_link u_pad_state_link (
    .hclk(hclk), .hrst_n(hrst_n), .host_word(host_word),
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .send_req(send_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int checks = 0, fails = 0;
  bit model_on = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Bench-side expectation of the button bytes from a settled host word.
  logic [31:0] settled_word = 0;
  function automatic logic [7:0] exp_b1(input logic [31:0] w);
    logic [7:0] v = 8'hFF;
    if (w[0]) v = v & 8'b1101_1111;
    if (w[5]) v = v & 8'b1111_1110;
    return v;
  endfunction

  // Reference model of the stream: queue of pending beats.
  logic [31:0] beatq[$];
  always @(posedge clk) begin
    if (!rst_n) beatq.delete();
    else if (beatq.size() == 0) begin
      if (send_req) begin
        beatq.push_back({exp_b1(settled_word), 8'h5A, 8'h41, 8'h00});
        beatq.push_back({24'h808080, 8'hFF});
        beatq.push_back(32'h80);
        beatq.push_back(32'h0);
      end
    end else if (tx_ready) void'(beatq.pop_front());
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R7 valid", {31'd0, tx_valid}, {31'd0, beatq.size() != 0});
      if (beatq.size() != 0) begin
        chk("R6/R8/R9 data", tx_data, beatq[0]);
        chk("R7 last", {31'd0, tx_last}, {31'd0, beatq.size() == 1});
      end
    end
  end

  task automatic set_host(input logic [31:0] w);
    @(negedge hclk); host_word = w;
    repeat (6) @(negedge clk);
    settled_word = w;
  endtask

  task automatic read_stat(input string req, input logic [31:0] addr, input logic [31:0] exp);
    @(negedge clk); rd_en = 1; rd_addr = addr;
    @(negedge clk); rd_en = 0;
    chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic request(input int stall_cycles);
    @(negedge clk); send_req = 1; tx_ready = 0;
    @(negedge clk); send_req = 0;
    repeat (stall_cycles) @(negedge clk);
  endtask

  task automatic drain(input logic [7:0] pat);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      tx_ready = pat[i % 8];
    end
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hrst_n = 1; rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", {31'd0, tx_valid}, 32'd0);
    read_stat("R1/R3 reset status", STAT, 32'h0000_FFFF);
    model_on = 1;

    set_host(32'h0);          read_stat("R3 zero word", STAT, 32'h0000_FFFF);
    set_host(32'h1);          read_stat("R4 right", STAT, 32'h0000_FFDF);
    set_host(32'h20);         read_stat("R4 select", STAT, 32'h0000_FFFE);
    set_host(32'h21);         read_stat("R4 both", STAT, 32'h0000_FFDE);
    set_host(32'hFFFF_FFDE);  read_stat("R5 unmapped bits", STAT, 32'h0000_FFFF);
    set_host(32'hFFFF_FFFF);  read_stat("R5 all bits", STAT, 32'h0000_FFDE);
    read_stat("R2 other address", 32'h1F80_8504, 32'h0);
    // R1: value visible within 4 core cycles of the host edge
    @(negedge hclk); host_word = 32'h1; @(posedge hclk);
    repeat (4) @(posedge clk);
    settled_word = 32'h1;
    @(negedge clk); rd_en = 1; rd_addr = STAT;
    @(negedge clk); rd_en = 0;
    chk("R1 latency", rd_data, 32'h0000_FFDF);

    // R6/R7 plain burst, ready always high
    request(0); drain(8'hFF);
    // R8 stalls with sparse ready
    set_host(32'h20); request(3); drain(8'b1001_0010);
    // R9 snapshot: change host word while stalled
    set_host(32'h21);
    request(1);
    @(negedge hclk); host_word = 32'h0;
    repeat (10) @(negedge clk);
    drain(8'b0101_0101);
    settled_word = 32'h0;
    // R10 request held high through and after burst: ignored while busy
    @(negedge clk); send_req = 1; tx_ready = 1;
    repeat (4) @(negedge clk);
    send_req = 0;
    repeat (8) @(negedge clk);
    tx_ready = 0;
    repeat (3) @(negedge clk);
    chk("R10 idle after", {31'd0, tx_valid}, 32'd0);

    model_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule